// File: doc/BRIEF.md
# PPS capture and interval monitor

This block takes an external pulse-per-second reference into the system clock domain. It gives the rest of the chip a single-cycle PPS pulse and a level that flips on every accepted pulse. Alongside that, it measures the length of each PPS period in clock cycles and keeps a live count of the cycles since the most recent pulse. A host can read that live count to align its own time of day with the hardware PPS.

A flag reports whether the last measured period matched a programmable expected length. All counters stop at their maximum when the reference goes missing. A small word-addressed register port holds the expected length and a choice of sampling clock edge, and it returns the captured status.

Everything runs on one clock. The counter width is the ceiling of log2 of the nominal clock frequency in hertz.

Top module: `pps_interval_mon`

## Requirements
- R1: After reset, word 0 reads 0x000003FF (level 0, match flag 0, captured period all-ones), word 1 reads 0x000003FF (edge select 0, expected length all-ones) and word 2 reads all-ones, for the default width of 10 bits.
- R2: On each detected PPS rising event, the captured period (word 0, bits 29:0) becomes the number of clock cycles since the previous event.
- R3: Word 2, bits 29:0, returns the running count of cycles since the last event, as captured in the cycle of the read. Two reads D cycles apart within one period differ by D, and the count restarts near zero after every event.
- R4: With no events, the running count stops at all-ones, the captured period is forced to all-ones and the match flag clears. The first event after that reports a period of all-ones.
- R5: Each PPS pulse, however many cycles it is held high, gives exactly one single-cycle `pps_pulse`. `pps_level` (word 0, bit 31) inverts on each such pulse.
- R6: On each event, the match flag (word 0, bit 30) is set if the new period equals the expected length and is cleared otherwise.
- R7: Writing word 0 with bit 30 set clears the match flag until the next event.
- R8: Word 1, bit 31, selects the sampling edge: 0 samples the PPS input on the rising clock edge, and 1 samples it on the falling edge and then retimes it to the rising edge. An input that changes in the late half of a clock period is seen one cycle later with 1 than with 0, so switching mid-stream lengthens or shortens one measured period by one cycle.
- R9: Word 1 is read/write (bit 31 edge select, bits W-1:0 expected length). Unused bits read as zero, and word 3 reads zero.
- R10: A read returns its data on `rdata` in the cycle after `rd_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | External PPS reference |
| pps_pulse | output | 1 | One-cycle internal PPS pulse |
| pps_level | output | 1 | Level that inverts on every accepted pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |

## Verification
The reference is driven with narrow and with wide pulses. This shows that the measured period and the pulse count do not depend on pulse width. Periods that match and then miss the expected length separate setting the match flag from clearing it. Switching the sampling edge mid-stream while the input changes late in the clock period gives one interval of P+1 or P-1, which shows the extra retiming stage. Stopping the reference for longer than the counter range exercises saturation and the all-ones first period that follows it.

// File: rtl/pps_interval_mon.sv
module pps_interval_mon #(
  parameter int CLK_HZ = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pps_in,
  output logic        pps_pulse,
  output logic        pps_level,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int W = $clog2(CLK_HZ);
  localparam logic [W-1:0] MAX = '1;

  logic cap_r, cap_f, cap_fr, s1, s2;
  logic evt, sat, ack, edge_sel, stable;
  logic [W-1:0] cnt, ivl, expc, meas;
  logic [31:0] rd_next;
  logic unused_bits;

  assign unused_bits = ^wdata[29:W];

  always_ff @(negedge clk) cap_f <= rst ? 1'b0 : pps_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_r  <= 1'b0;
      cap_fr <= 1'b0;
      s1     <= 1'b0;
      s2     <= 1'b0;
    end else begin
      cap_r  <= pps_in;
      cap_fr <= cap_f;
      s1     <= edge_sel ? cap_fr : cap_r;
      s2     <= s1;
    end
  end

  assign evt  = s1 & ~s2;
  assign sat  = (cnt == MAX);
  assign meas = sat ? MAX : cnt + 1'b1;
  assign ack  = wr_en && addr == 2'd0 && wdata[30];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= MAX;
      ivl <= MAX;
    end else if (evt) begin
      cnt <= '0;
      ivl <= meas;
    end else if (sat) begin
      ivl <= MAX;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stable    <= 1'b0;
      pps_level <= 1'b0;
      pps_pulse <= 1'b0;
    end else begin
      pps_pulse <= evt;
      if (evt) pps_level <= ~pps_level;
      if (evt)      stable <= (meas == expc);
      else if (sat) stable <= 1'b0;
      else if (ack) stable <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_sel <= 1'b0;
      expc     <= MAX;
    end else if (wr_en && addr == 2'd1) begin
      edge_sel <= wdata[31];
      expc     <= wdata[W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      2'd0: begin
        rd_next[W-1:0] = ivl;
        rd_next[31]    = pps_level;
        rd_next[30]    = stable;
      end
      2'd1: begin
        rd_next[W-1:0] = expc;
        rd_next[31]    = edge_sel;
      end
      2'd2: rd_next[W-1:0] = cnt;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end
endmodule

// File: rtl/pps_interval_mon_chk.sv
module pps_interval_mon_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         evt,
  input logic [W-1:0] cnt,
  input logic [W-1:0] ivl,
  input logic         pps_pulse,
  input logic         pps_level,
  input logic         stable,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic         ack_bit
);
  localparam logic [W-1:0] MAX = '1;

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    pps_pulse |=> !pps_pulse);

  p_level_follows_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    pps_pulse == (pps_level != $past(pps_level)));

  p_offset_restart_r3: assert property (@(posedge clk) disable iff (rst)
    pps_pulse |-> cnt == '0);

  p_offset_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!evt && cnt != MAX) |=> cnt == $past(cnt) + 1'b1);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (!evt && cnt == MAX) |=> (cnt == MAX && ivl == MAX && !stable));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0 && ack_bit && !evt) |=> !stable);
endmodule

bind pps_interval_mon pps_interval_mon_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .cnt(cnt), .ivl(ivl),
  .pps_pulse(pps_pulse), .pps_level(pps_level), .stable(stable),
  .wr_en(wr_en), .addr(addr), .ack_bit(wdata[30])
);

// File: tb/sim_pps_interval_mon.sv
module sim_pps_interval_mon;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 1000;
  localparam int W = $clog2(CLK_HZ);
  localparam logic [31:0] MAXV = 32'((1 << W) - 1);
  localparam logic [31:0] M_ALL = 32'hFFFF_FFFF;
  localparam logic [31:0] M_NOTOG = 32'h7FFF_FFFF;
  localparam logic [31:0] M_IVL = 32'h3FFF_FFFF;

  logic clk = 1'b0, rst = 1'b1, pps_in = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic pps_pulse, pps_level;
  logic [31:0] rdata;

  int checks = 0, errors = 0;
  int gen_on = 0, gen_period = 200, gen_width = 1, gcnt = 0, pulses_sent = 0;
  int pulse_seen = 0;
  logic pend = 1'b0;
  logic [31:0] last_off = '0;

  typedef struct {
    logic [31:0] mask;
    logic [31:0] expv;
    int          mode;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pps_interval_mon #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst(rst), .pps_in(pps_in), .pps_pulse(pps_pulse),
    .pps_level(pps_level), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  initial forever begin
    @(posedge clk);
    #(3*CLK_PERIOD/4);
    if (gen_on != 0) begin
      if (gcnt == 0) pulses_sent++;
      pps_in = (gcnt < gen_width);
      gcnt = (gcnt == gen_period - 1) ? 0 : gcnt + 1;
    end else begin
      pps_in = 1'b0;
      gcnt = 0;
    end
  end

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    item_t it;
    if (!rst && pps_pulse) pulse_seen++;
    if (pend) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 read data with no pending request: actual %h expected none", rdata);
      end else begin
        it = sbq.pop_front();
        case (it.mode)
          1: last_off = rdata & it.mask;
          2: begin
            checks++;
            if (((rdata & it.mask) - last_off) != it.expv) begin
              errors++;
              $display("FAIL %s: actual delta %0d expected %0d", it.tag, (rdata & it.mask) - last_off, it.expv);
            end
            last_off = rdata & it.mask;
          end
          3: begin
            checks++;
            if ((rdata & it.mask) >= it.expv) begin
              errors++;
              $display("FAIL %s: actual %0d expected below %0d", it.tag, rdata & it.mask, it.expv);
            end
          end
          default: begin
            checks++;
            if ((rdata & it.mask) != (it.expv & it.mask)) begin
              errors++;
              $display("FAIL %s: actual %h expected %h", it.tag, rdata & it.mask, it.expv & it.mask);
            end
          end
        endcase
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] m, input logic [31:0] e,
                    input int md, input string t);
    item_t it;
    it.mask = m; it.expv = e; it.mode = md; it.tag = t;
    sbq.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic wait_phase(input int x);
    do @(negedge clk); while (gcnt != x);
  endtask

  task automatic check_int(input int act, input int exp, input string t);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    checks++; errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state, R9 unused word
    rd(2'd0, M_ALL, MAXV, 0, "R1 word0 after reset");
    rd(2'd1, M_ALL, MAXV, 0, "R1 word1 after reset");
    rd(2'd2, M_ALL, MAXV, 0, "R1 offset after reset");
    rd(2'd3, M_ALL, 32'h0, 0, "R9 word3 reads zero");
    check_int(int'(pps_level), 0, "R1 level after reset");

    wr(2'd1, 32'd200);
    rd(2'd1, M_ALL, 32'd200, 0, "R9 word1 readback");

    // R2 R6 matched period, narrow pulses
    gen_period = 200; gen_width = 1; gen_on = 1;
    repeat (700) @(negedge clk);
    rd(2'd0, M_NOTOG, (32'd1 << 30) | 32'd200, 0, "R2 R6 period 200 matched");

    // R3 offset deltas and restart, R10 one-cycle read timing
    wait_phase(10);
    rd(2'd2, M_ALL, 0, 1, "R3 offset first");
    repeat (49) @(negedge clk);
    rd(2'd2, M_ALL, 32'd50, 2, "R3 offset delta 50");
    repeat (99) @(negedge clk);
    rd(2'd2, M_ALL, 32'd100, 2, "R3 offset delta 100");
    wait_phase(10);
    rd(2'd2, M_ALL, 32'd16, 3, "R3 offset restart");

    // R5 wide pulses still one event each
    wait_phase(100);
    gen_width = 50;
    wait_phase(100); wait_phase(100);
    rd(2'd0, M_NOTOG, (32'd1 << 30) | 32'd200, 0, "R2 R5 wide pulse period");

    // R6 mismatch then match
    wr(2'd1, 32'd201);
    wait_phase(20);
    rd(2'd0, M_NOTOG, 32'd200, 0, "R6 mismatch clears flag");
    wr(2'd1, 32'd200);
    wait_phase(20);
    rd(2'd0, M_NOTOG, (32'd1 << 30) | 32'd200, 0, "R6 match sets flag");

    // R7 acknowledge
    wait_phase(30);
    wr(2'd0, 32'h4000_0000);
    rd(2'd0, M_NOTOG, 32'd200, 0, "R7 ack clears flag");
    wait_phase(20);
    rd(2'd0, M_NOTOG, (32'd1 << 30) | 32'd200, 0, "R7 flag set again");

    // R8 falling-edge sampling
    wait_phase(100);
    wr(2'd1, 32'h8000_0000 | 32'd200);
    rd(2'd1, M_ALL, 32'h8000_0000 | 32'd200, 0, "R8 edge bit readback");
    wait_phase(20);
    rd(2'd0, M_NOTOG, 32'd201, 0, "R8 switch to falling adds a cycle");
    wait_phase(20);
    rd(2'd0, M_NOTOG, (32'd1 << 30) | 32'd200, 0, "R8 falling steady");
    wait_phase(100);
    wr(2'd1, 32'd200);
    wait_phase(20);
    rd(2'd0, M_NOTOG, 32'd199, 0, "R8 switch to rising drops a cycle");
    wait_phase(20);
    rd(2'd0, M_NOTOG, (32'd1 << 30) | 32'd200, 0, "R8 rising steady");

    // R5 toggle parity and pulse count
    wait_phase(100);
    gen_on = 0;
    repeat (20) @(negedge clk);
    rd(2'd0, 32'h8000_0000, (pulses_sent % 2 == 1) ? 32'h8000_0000 : 32'h0, 0, "R5 level parity");
    check_int(pulse_seen, pulses_sent, "R5 one pulse per PPS");

    // R4 saturation
    repeat (1100) @(negedge clk);
    rd(2'd0, M_NOTOG, MAXV, 0, "R4 period saturates");
    rd(2'd2, M_ALL, MAXV, 0, "R4 offset saturates");
    gen_width = 1; gen_on = 1;
    wait_phase(20);
    rd(2'd0, M_NOTOG, MAXV, 0, "R4 first period after loss");
    wait_phase(20);
    rd(2'd0, M_NOTOG, (32'd1 << 30) | 32'd200, 0, "R4 R2 recovered period");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule